// File: doc/BRIEF.md
# DMA Transfer Length and Termination Engine

This block decides how long a slave-side DMA transfer runs and when it stops. Software programs a 32-bit beat count one byte at a time, picks the termination style and the strobe that qualifies a data beat, then issues a read or write command. While the transfer is active, the engine counts qualified beats coming from an external DMA master. It stops on whichever comes first: the count running out, an end-of-transfer pin driven by the master, or a short-packet indication from the packet engine.

The count bytes collect in a shadow register. They replace the working count only when the top byte is written, so a half-written value never reaches the decrementer. A configuration bit turns the counter off. In that mode the count register still accepts writes, but only the two end-of-transfer sources can stop a transfer. When a transfer ends, a sticky completion flag is set. The flag is cleared by writing a one to it. It drives the interrupt output through an enable bit.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, busy, the direction output, irq, the completion flag, the configuration register (0x38) and all four count bytes (0x34..0x37) read as zero.
- R2: Writes to 0x34, 0x35 and 0x36 only fill a shadow and leave the working count (read back at 0x34..0x37, 0x34 least significant) unchanged. A write to 0x37 loads the working count with that byte as bits 31:24 and the shadowed bytes below it.
- R3: Writing 0x00 to command address 0x30 starts a read transfer (xfer_dir = 0). Writing 0x01 starts a write transfer (xfer_dir = 1). busy rises on the edge that takes the write. Any other opcode is ignored. Address 0x30 reads back the direction in bit 0.
- R4: In counter mode (0x38 bit 0 = 0), each qualified beat while busy lowers the count by one. The beat that brings the count to zero drops busy and sets the completion flag on that same edge.
- R5: Configuration bits 2:1 pick the qualifying strobe: 00 = stb_ack, 01 = stb_rd, 10 = stb_wr, and 11 acts as 00. Strobes that are not selected do not change the count.
- R6: ext_eot high while busy ends the transfer and sets the completion flag at the next edge. This holds in either mode and whatever count remains.
- R7: In end-of-transfer-only mode (0x38 bit 0 = 1), beats neither change the count nor end the transfer. Writes to 0x37 still load the count without ending the transfer.
- R8: short_pkt high while busy ends the transfer in end-of-transfer-only mode. It is ignored in counter mode.
- R9: The completion flag reads at 0x31 bit 0. Writing a 1 there clears it, writing a 0 has no effect, and a completion in the same cycle as the clear wins.
- R10: irq equals the completion flag ANDed with the interrupt enable at 0x38 bit 3.
- R11: A command written while busy is ignored: busy, the direction and the count are unchanged.
- R12: In counter mode, a command issued with a working count of zero leaves busy low and sets the completion flag on the edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| stb_ack | input | 1 | DMA acknowledge strobe from master |
| stb_rd | input | 1 | Read strobe from master |
| stb_wr | input | 1 | Write strobe from master |
| ext_eot | input | 1 | External end-of-transfer from master |
| short_pkt | input | 1 | Internal short-packet indication |
| busy | output | 1 | Transfer active |
| xfer_dir | output | 1 | Direction of the current or last transfer, 1 = write |
| irq | output | 1 | Completion interrupt |

## Verification
If the working count is off, it shows at the count readback right after the next beat. It also shows as busy falling one or more beats early or late. If the shadow path is wrong, the readback changes after a lower-byte write, before any beat happens. A stuck or leaking termination term shows within one clock as busy failing to drop, or dropping with the completion flag and irq out of step. The mode-selection corners each use a strobe that must leave the count alone, so a wrong mux leg shows on the very next readback.

// File: rtl/dma_xfer_pkg.sv
// Package: shared types and constants for the DMA transfer engine.
// Assumes an 8-bit register data path for the opcode values.
package dma_xfer_pkg;

    // Strobe that qualifies one data beat.
    typedef enum logic [1:0] {
        STB_ACK = 2'b00,
        STB_RD  = 2'b01,
        STB_WR  = 2'b10,
        STB_RSV = 2'b11
    } strobe_sel_e;

    // Configuration register layout, bit 3 down to bit 0.
    typedef struct packed {
        logic        ien;
        strobe_sel_e mode;
        logic        cnt_off;
    } cfg_t;

    localparam int CFG_W    = $bits(cfg_t);
    localparam int OP_READ  = 8'h00;
    localparam int OP_WRITE = 8'h01;

endpackage

// File: rtl/dma_xfer_regs.sv
// Register slice: count shadow bytes, configuration, completion flag
// and command decode. Assumes CNT_W is a whole multiple of DATA_W and
// that the top count byte sits at the highest count address.
module dma_xfer_regs
    import dma_xfer_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter int                CNT_W     = 32,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h30,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h31,
    parameter logic [ADDR_W-1:0] CNT_BASE  = 8'h34,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              done_set,
    output cfg_t              cfg,
    output logic              done_q,
    output logic              ld_msb,
    output logic [CNT_W-1:0]  ld_value,
    output logic              cmd_wr,
    output logic              cmd_dir
);

    localparam int                NB       = CNT_W / DATA_W;
    localparam int                SH_W     = (NB - 1) * DATA_W;
    localparam logic [ADDR_W-1:0] MSB_ADDR = CNT_BASE + ADDR_W'(NB - 1);

    logic [SH_W-1:0] shadow_q;
    logic            wr_stat;
    logic            wr_cfg;
    logic            wr_cmd;
    logic            op_ok;

    assign wr_stat = reg_wr && (reg_addr == STAT_ADDR);
    assign wr_cfg  = reg_wr && (reg_addr == CFG_ADDR);
    assign wr_cmd  = reg_wr && (reg_addr == CMD_ADDR);
    assign op_ok   = (reg_wdata == DATA_W'(OP_READ)) || (reg_wdata == DATA_W'(OP_WRITE));

    // Capture the lower count bytes into the shadow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (reg_wr) begin
            for (int i = 0; i < NB - 1; i++) begin
                if (reg_addr == CNT_BASE + ADDR_W'(i)) begin
                    shadow_q[i*DATA_W +: DATA_W] <= reg_wdata;
                end
            end
        end
    end

    // Hold the configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_cfg) begin
            cfg <= cfg_t'(reg_wdata[CFG_W-1:0]);
        end
    end

    // Sticky completion flag; a set beats a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (done_set) begin
            done_q <= 1'b1;
        end else if (wr_stat && reg_wdata[0]) begin
            done_q <= 1'b0;
        end
    end

    // Top-byte write commits the whole count.
    assign ld_msb   = reg_wr && (reg_addr == MSB_ADDR);
    assign ld_value = {reg_wdata, shadow_q};

    // Valid opcodes only become commands.
    assign cmd_wr  = wr_cmd && op_ok;
    assign cmd_dir = reg_wdata[0];

endmodule

// File: rtl/dma_beat_sel.sv
// Beat qualifier: picks the master strobe named by the mode field.
// The reserved code falls back to the acknowledge strobe.
module dma_beat_sel
    import dma_xfer_pkg::*;
(
    input  strobe_sel_e mode,
    input  logic        stb_ack,
    input  logic        stb_rd,
    input  logic        stb_wr,
    output logic        beat
);

    // Route the selected strobe to the beat line.
    always_comb begin
        unique case (mode)
            STB_RD:  beat = stb_rd;
            STB_WR:  beat = stb_wr;
            default: beat = stb_ack;
        endcase
    end

endmodule

// File: rtl/dma_xfer_ctl.sv
// Transfer controller: working count, busy and direction, and the
// termination decision. Assumes the terminating inputs are synchronous
// to clk; termination lands on the edge that samples the event.
module dma_xfer_ctl #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_off,
    input  logic             cmd_wr,
    input  logic             cmd_dir,
    input  logic             ld_msb,
    input  logic [CNT_W-1:0] ld_value,
    input  logic             beat,
    input  logic             ext_eot,
    input  logic             short_pkt,
    output logic             busy,
    output logic             dir,
    output logic [CNT_W-1:0] cnt_q,
    output logic             done_set
);

    logic cnt_zero;
    logic cnt_last;
    logic term_now;
    logic zero_start;
    logic do_dec;

    assign cnt_zero = (cnt_q == '0);
    assign cnt_last = (cnt_q == CNT_W'(1));

    // Decide which event, if any, stops the running transfer.
    always_comb begin
        term_now = 1'b0;
        if (busy) begin
            if (ext_eot) begin
                term_now = 1'b1;
            end else if (cnt_off) begin
                term_now = short_pkt;
            end else begin
                term_now = cnt_zero || (beat && cnt_last);
            end
        end
    end

    assign zero_start = !busy && cmd_wr && !cnt_off && cnt_zero;
    assign do_dec     = busy && !cnt_off && beat && !cnt_zero;
    assign done_set   = term_now || zero_start;

    // Working count: a load wins over a beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_msb) begin
            cnt_q <= ld_value;
        end else if (do_dec) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Busy and direction: start on an accepted command, stop on termination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            dir  <= 1'b0;
        end else if (busy) begin
            if (term_now) begin
                busy <= 1'b0;
            end
        end else if (cmd_wr) begin
            dir  <= cmd_dir;
            busy <= !zero_start;
        end
    end

endmodule

// File: rtl/dma_xfer_engine.sv
// Top: DMA transfer length and termination engine. Joins the register
// slice, the beat qualifier and the controller, and forms readback and
// interrupt. Readback is combinational from the address.
module dma_xfer_engine
    import dma_xfer_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter int                CNT_W     = 32,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h30,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h31,
    parameter logic [ADDR_W-1:0] CNT_BASE  = 8'h34,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              stb_ack,
    input  logic              stb_rd,
    input  logic              stb_wr,
    input  logic              ext_eot,
    input  logic              short_pkt,
    output logic              busy,
    output logic              xfer_dir,
    output logic              irq
);

    localparam int NB = CNT_W / DATA_W;

    cfg_t             cfg;
    logic             done_q;
    logic             done_set;
    logic             ld_msb;
    logic [CNT_W-1:0] ld_value;
    logic             cmd_wr;
    logic             cmd_dir;
    logic             beat;
    logic [CNT_W-1:0] cnt_q;

    dma_xfer_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .CMD_ADDR(CMD_ADDR), .STAT_ADDR(STAT_ADDR),
        .CNT_BASE(CNT_BASE), .CFG_ADDR(CFG_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .done_set(done_set),
        .cfg(cfg), .done_q(done_q),
        .ld_msb(ld_msb), .ld_value(ld_value),
        .cmd_wr(cmd_wr), .cmd_dir(cmd_dir)
    );

    dma_beat_sel u_sel (
        .mode(cfg.mode),
        .stb_ack(stb_ack), .stb_rd(stb_rd), .stb_wr(stb_wr),
        .beat(beat)
    );

    dma_xfer_ctl #(.CNT_W(CNT_W)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .cnt_off(cfg.cnt_off),
        .cmd_wr(cmd_wr), .cmd_dir(cmd_dir),
        .ld_msb(ld_msb), .ld_value(ld_value),
        .beat(beat), .ext_eot(ext_eot), .short_pkt(short_pkt),
        .busy(busy), .dir(xfer_dir), .cnt_q(cnt_q),
        .done_set(done_set)
    );

    // Gate the completion flag with its enable.
    assign irq = done_q && cfg.ien;

    // Readback multiplexer over the register addresses.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CMD_ADDR) begin
            reg_rdata = DATA_W'(xfer_dir);
        end else if (reg_addr == STAT_ADDR) begin
            reg_rdata = DATA_W'(done_q);
        end else if (reg_addr == CFG_ADDR) begin
            reg_rdata = DATA_W'(cfg);
        end else begin
            for (int i = 0; i < NB; i++) begin
                if (reg_addr == CNT_BASE + ADDR_W'(i)) begin
                    reg_rdata = cnt_q[i*DATA_W +: DATA_W];
                end
            end
        end
    end

endmodule

// File: rtl/dma_xfer_engine_chk.sv
// Checker: temporal properties of the transfer engine, bound to the top.
module dma_xfer_engine_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             dir,
    input logic             done,
    input logic             cnt_off,
    input logic             beat,
    input logic             ld_msb,
    input logic             cmd_wr,
    input logic             ext_eot,
    input logic [CNT_W-1:0] cnt
);

    a_r2_load_only_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ld_msb) |=> $stable(cnt));

    a_r4_beat_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cnt_off && beat && !ld_msb && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

    a_r6_eot_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ext_eot) |=> (!busy && done));

    a_r7_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_off && !ld_msb) |=> $stable(cnt));

    a_r11_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dir));

    a_r12_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wr && !cnt_off && cnt == '0) |=> (!busy && done));

    a_r4_end_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .dir(xfer_dir), .done(done_q),
    .cnt_off(cfg.cnt_off), .beat(beat), .ld_msb(ld_msb), .cmd_wr(cmd_wr),
    .ext_eot(ext_eot), .cnt(cnt_q)
);

// File: tb/dma_xfer_engine_test.sv
// Directed bench for the DMA transfer engine; one task per scenario.
module dma_xfer_engine_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       stb_ack = 1'b0, stb_rd = 1'b0, stb_wr = 1'b0;
    logic       ext_eot = 1'b0, short_pkt = 1'b0;
    logic       busy, xfer_dir, irq;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    dma_xfer_engine uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .stb_ack(stb_ack), .stb_rd(stb_rd), .stb_wr(stb_wr),
        .ext_eot(ext_eot), .short_pkt(short_pkt),
        .busy(busy), .xfer_dir(xfer_dir), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic rd_cnt(output logic [31:0] v);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd(8'h34 + 8'(i), b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic load_cnt(input logic [31:0] c);
        for (int i = 0; i < 4; i++) wr(8'h34 + 8'(i), c[i*8 +: 8]);
    endtask

    // which: 0 ack, 1 rd, 2 wr, 3 eot, 4 short packet
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: stb_ack = 1'b1;
            1: stb_rd = 1'b1;
            2: stb_wr = 1'b1;
            3: ext_eot = 1'b1;
            default: short_pkt = 1'b1;
        endcase
        @(negedge clk);
        stb_ack = 1'b0; stb_rd = 1'b0; stb_wr = 1'b0;
        ext_eot = 1'b0; short_pkt = 1'b0;
    endtask

    task automatic done_flag(output logic f);
        logic [7:0] v;
        rd(8'h31, v);
        f = v[0];
    endtask

    task automatic t_reset();
        logic [31:0] c; logic [7:0] v; logic f;
        rd_cnt(c);          chk("R1 count", c, 0);
        rd(8'h38, v);       chk("R1 config", v, 0);
        done_flag(f);       chk("R1 done", f, 0);
        chk("R1 busy", busy, 0);
        chk("R1 dir", xfer_dir, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_count_load();
        logic [31:0] c;
        wr(8'h34, 8'h11); wr(8'h35, 8'h22); wr(8'h36, 8'h33);
        rd_cnt(c);          chk("R2 lower bytes shadowed", c, 0);
        wr(8'h37, 8'h44);
        rd_cnt(c);          chk("R2 msb commit", c, 32'h44332211);
    endtask

    task automatic t_counter_mode();
        logic [31:0] c; logic f;
        wr(8'h38, 8'h08);
        load_cnt(3);
        wr(8'h30, 8'h01);
        chk("R3 busy on write cmd", busy, 1);
        chk("R3 dir write", xfer_dir, 1);
        pulse(0); rd_cnt(c); chk("R4 decrement", c, 2);
        pulse(1); rd_cnt(c); chk("R5 unselected rd ignored", c, 2);
        pulse(3'd2); rd_cnt(c); chk("R5 unselected wr ignored", c, 2);
        pulse(0); chk("R4 still busy at 1", busy, 1);
        pulse(0);
        chk("R4 busy falls at zero", busy, 0);
        done_flag(f); chk("R4 done set", f, 1);
        chk("R10 irq enabled", irq, 1);
        rd_cnt(c); chk("R4 count zero", c, 0);
        wr(8'h31, 8'h00); done_flag(f); chk("R9 write zero keeps", f, 1);
        wr(8'h31, 8'h01); done_flag(f); chk("R9 write one clears", f, 0);
        chk("R10 irq follows clear", irq, 0);
    endtask

    task automatic t_mode_select();
        logic [31:0] c; logic f;
        wr(8'h38, 8'h02);           // rd strobe, no irq
        load_cnt(2);
        wr(8'h30, 8'h00);
        chk("R3 dir read", xfer_dir, 0);
        pulse(0); rd_cnt(c); chk("R5 ack ignored in rd mode", c, 2);
        pulse(2); rd_cnt(c); chk("R5 wr ignored in rd mode", c, 2);
        pulse(1); rd_cnt(c); chk("R5 rd counts", c, 1);
        pulse(1); chk("R5 rd mode ends", busy, 0);
        chk("R10 irq masked", irq, 0);
        wr(8'h31, 8'h01);
        wr(8'h38, 8'h04);           // wr strobe
        load_cnt(1); wr(8'h30, 8'h01);
        pulse(1); chk("R5 rd ignored in wr mode", busy, 1);
        pulse(2); chk("R5 wr mode ends", busy, 0);
        wr(8'h31, 8'h01);
        wr(8'h38, 8'h06);           // reserved, acts as ack
        load_cnt(1); wr(8'h30, 8'h01);
        pulse(2); chk("R5 reserved ignores wr", busy, 1);
        pulse(0); chk("R5 reserved uses ack", busy, 0);
        done_flag(f); chk("R5 reserved done", f, 1);
        wr(8'h31, 8'h01);
    endtask

    task automatic t_ext_eot();
        logic [31:0] c; logic f;
        wr(8'h38, 8'h00);
        load_cnt(100); wr(8'h30, 8'h01);
        pulse(0); rd_cnt(c); chk("R4 count 99", c, 99);
        pulse(3);
        chk("R6 eot ends", busy, 0);
        done_flag(f); chk("R6 eot done", f, 1);
        rd_cnt(c); chk("R6 count kept", c, 99);
        wr(8'h31, 8'h01);
    endtask

    task automatic t_eot_only();
        logic [31:0] c; logic f;
        wr(8'h38, 8'h01);
        load_cnt(2); wr(8'h30, 8'h00);
        pulse(0); pulse(0); pulse(0);
        chk("R7 beats do not end", busy, 1);
        rd_cnt(c); chk("R7 count frozen", c, 2);
        load_cnt(5);
        rd_cnt(c); chk("R7 count loads", c, 5);
        chk("R7 load does not end", busy, 1);
        pulse(4);
        chk("R8 short packet ends", busy, 0);
        done_flag(f); chk("R8 done", f, 1);
        wr(8'h31, 8'h01);
        wr(8'h30, 8'h01); pulse(3);
        chk("R6 eot ends eot-only", busy, 0);
        wr(8'h31, 8'h01);
    endtask

    task automatic t_short_counter();
        logic f;
        wr(8'h38, 8'h00);
        load_cnt(4); wr(8'h30, 8'h01);
        pulse(4);
        chk("R8 short ignored in counter mode", busy, 1);
        done_flag(f); chk("R8 no done", f, 0);
        pulse(3);
        chk("R6 eot after short", busy, 0);
        wr(8'h31, 8'h01);
    endtask

    task automatic t_cmd_busy();
        logic [31:0] c;
        wr(8'h38, 8'h00);
        load_cnt(5); wr(8'h30, 8'h01);
        wr(8'h30, 8'h00);
        chk("R11 dir kept", xfer_dir, 1);
        chk("R11 busy kept", busy, 1);
        rd_cnt(c); chk("R11 count kept", c, 5);
        pulse(3); wr(8'h31, 8'h01);
        wr(8'h30, 8'h02);
        chk("R3 bad opcode ignored", busy, 0);
        chk("R3 bad opcode dir", xfer_dir, 1);
    endtask

    task automatic t_zero_count();
        logic f;
        wr(8'h38, 8'h08);
        load_cnt(0);
        wr(8'h30, 8'h00);
        chk("R12 busy stays low", busy, 0);
        done_flag(f); chk("R12 done at once", f, 1);
        chk("R12 irq", irq, 1);
        wr(8'h31, 8'h01);
    endtask

    task automatic t_set_wins();
        logic f;
        wr(8'h38, 8'h00);
        load_cnt(1); wr(8'h30, 8'h01);
        @(negedge clk);
        stb_ack = 1'b1; reg_wr = 1'b1; reg_addr = 8'h31; reg_wdata = 8'h01;
        @(negedge clk);
        stb_ack = 1'b0; reg_wr = 1'b0;
        done_flag(f); chk("R9 set beats clear", f, 1);
        chk("R4 last beat ends", busy, 0);
        wr(8'h31, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count_load();
        t_counter_mode();
        t_mode_select();
        t_ext_eot();
        t_eot_only();
        t_short_counter();
        t_cmd_busy();
        t_zero_count();
        t_set_wins();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule